// File: doc/BRIEF.md
# Combo Memory Bank Select Decoder

This block sits in front of a package that stacks a flash array and a pseudo-SRAM array on one shared address, data and control bus. It reads the bus-side chip enables and produces per-bank activity, a standby indication, read and write strobes for each bank, and a per-lane output enable for the 16-bit data bus. It also forms the effective flash address in byte-wide operation, where the top data pin becomes the extra least significant address bit.

The pseudo-SRAM has two enables of opposite polarity. The flash has one active-low enable. When both banks are selected at once, the bus contends. The block raises a contention flag, keeps both banks idle and releases every data lane. A registered copy of the flag, taken on a free-running clock, lets the surrounding logic count the illegal cycles. Everything except that copy is combinational.

Top module: `combo_bank_decoder`

## Requirements
- R1: `flash_act` is 1 exactly when `flash_ce_n` is 0 and no contention exists.
- R2: `psram_act` is 1 exactly when `ps_ce1_n` is 0, `ps_ce2` is 1 and no contention exists.
- R3: When `flash_ce_n`=0, `ps_ce1_n`=0 and `ps_ce2`=1, `contention` is 1, and both bank actives, both write strobes and all 16 bits of `lane_oe` are 0. Otherwise `contention` is 0.
- R4: `standby` is 1 exactly when `flash_ce_n` is 1 and the pseudo-SRAM is not selected (`ps_ce1_n`=1 or `ps_ce2`=0).
- R5: For a flash read (`flash_act`=1, `oe_n`=0) lanes are driven. With no active bank or with `oe_n`=1, `lane_oe` is all zero.
- R6: In a flash read with `word_mode`=1, `lane_oe` is 16'hFFFF. With `word_mode`=0, it is 16'h00FF: lanes 8 to 15 stay released.
- R7: `flash_addr` is ADDR_W+1 bits wide. With `word_mode`=0 it is {`addr`, `dq_msb`}. With `word_mode`=1 it is {1'b0, `addr`}.
- R8: `psram_wr` is 1 exactly when `psram_act`=1, `we_n`=0 and `oe_n`=1.
- R9: `flash_wr` is 1 exactly when `flash_act`=1, `we_n`=0 and `oe_n`=1. A low `oe_n` inhibits the write.
- R10: `contention_q` is 0 in the cycle after a clock edge with `rst`=1. Otherwise it equals the value `contention` had at the previous rising clock edge.
- R11: In a pseudo-SRAM read (`psram_act`=1, `oe_n`=0), `lane_oe` is 16'hFFFF whatever the value of `word_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for the contention register |
| rst | input | 1 | Synchronous active-high reset |
| flash_ce_n | input | 1 | Flash bank enable, active low |
| ps_ce1_n | input | 1 | Pseudo-SRAM enable, active low |
| ps_ce2 | input | 1 | Pseudo-SRAM enable, active high |
| oe_n | input | 1 | Shared output enable, active low |
| we_n | input | 1 | Shared write enable, active low |
| word_mode | input | 1 | Flash width select: 1 = 16-bit, 0 = 8-bit |
| dq_msb | input | 1 | Top data pin, used as address bit in byte mode |
| addr | input | ADDR_W | Shared address pins |
| flash_act | output | 1 | Flash bank active |
| psram_act | output | 1 | Pseudo-SRAM bank active |
| standby | output | 1 | Neither bank selected |
| contention | output | 1 | Illegal simultaneous selection |
| contention_q | output | 1 | Contention flag registered on clk |
| flash_wr | output | 1 | Qualified flash write strobe |
| psram_wr | output | 1 | Qualified pseudo-SRAM write strobe |
| lane_oe | output | DATA_W | Per-lane data output enable |
| flash_addr | output | ADDR_W+1 | Effective flash address |

## Verification
The hardest case is a contention cycle that overlaps a read with `oe_n` low, `we_n` low and byte mode, while the top data pin toggles. In that cycle every strobe and lane must stay quiet, and the registered flag must follow one edge later. The stimulus walks all 128 combinations of the seven single-bit controls against four address patterns. Each contention code therefore meets every read, write and width setting and every value of the top pin. A reset held while the contention code is applied shows that the flag register clears even under an illegal selection.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  typedef struct packed {
    logic flash_sel;
    logic psram_sel;
    logic clash;
  } bank_sel_t;
endpackage

// File: rtl/cbd_enable_decode.sv
module cbd_enable_decode
  import cbd_pkg::*;
(
  input  logic      flash_ce_n,
  input  logic      ps_ce1_n,
  input  logic      ps_ce2,
  input  logic      oe_n,
  input  logic      we_n,
  output bank_sel_t sel,
  output logic      standby,
  output logic      flash_rd,
  output logic      psram_rd,
  output logic      flash_wr,
  output logic      psram_wr
);
  logic f_req, p_req;

  always_comb begin
    f_req         = ~flash_ce_n;
    p_req         = ~ps_ce1_n & ps_ce2;
    sel.clash     = f_req & p_req;
    sel.flash_sel = f_req & ~sel.clash;
    sel.psram_sel = p_req & ~sel.clash;
    standby       = ~f_req & ~p_req;
    flash_rd      = sel.flash_sel & ~oe_n;
    psram_rd      = sel.psram_sel & ~oe_n;
    flash_wr      = sel.flash_sel & ~we_n & oe_n;
    psram_wr      = sel.psram_sel & ~we_n & oe_n;
  end
endmodule

// File: rtl/cbd_lane_ctrl.sv
module cbd_lane_ctrl #(
  parameter int DATA_W = 16
) (
  input  logic              flash_rd,
  input  logic              psram_rd,
  input  logic              word_mode,
  output logic [DATA_W-1:0] lane_oe
);
  localparam int LOW_LANES = DATA_W / 2;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    if (i < LOW_LANES) begin : g_low
      assign lane_oe[i] = flash_rd | psram_rd;
    end else begin : g_high
      assign lane_oe[i] = psram_rd | (flash_rd & word_mode);
    end
  end
endmodule

// File: rtl/cbd_addr_form.sv
module cbd_addr_form #(
  parameter int ADDR_W = 21
) (
  input  logic            word_mode,
  input  logic            dq_msb,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W:0]   flash_addr
);
  always_comb begin
    if (word_mode) flash_addr = {1'b0, addr};
    else           flash_addr = {addr, dq_msb};
  end
endmodule

// File: rtl/combo_bank_decoder.sv
module combo_bank_decoder
  import cbd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flash_ce_n,
  input  logic              ps_ce1_n,
  input  logic              ps_ce2,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              word_mode,
  input  logic              dq_msb,
  input  logic [ADDR_W-1:0] addr,
  output logic              flash_act,
  output logic              psram_act,
  output logic              standby,
  output logic              contention,
  output logic              contention_q,
  output logic              flash_wr,
  output logic              psram_wr,
  output logic [DATA_W-1:0] lane_oe,
  output logic [ADDR_W:0]   flash_addr
);
  bank_sel_t sel;
  logic      flash_rd, psram_rd;

  cbd_enable_decode u_dec (
    .flash_ce_n (flash_ce_n),
    .ps_ce1_n   (ps_ce1_n),
    .ps_ce2     (ps_ce2),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .sel        (sel),
    .standby    (standby),
    .flash_rd   (flash_rd),
    .psram_rd   (psram_rd),
    .flash_wr   (flash_wr),
    .psram_wr   (psram_wr)
  );

  cbd_lane_ctrl #(.DATA_W(DATA_W)) u_lanes (
    .flash_rd  (flash_rd),
    .psram_rd  (psram_rd),
    .word_mode (word_mode),
    .lane_oe   (lane_oe)
  );

  cbd_addr_form #(.ADDR_W(ADDR_W)) u_addr (
    .word_mode  (word_mode),
    .dq_msb     (dq_msb),
    .addr       (addr),
    .flash_addr (flash_addr)
  );

  assign flash_act  = sel.flash_sel;
  assign psram_act  = sel.psram_sel;
  assign contention = sel.clash;

  always_ff @(posedge clk) begin
    if (rst) contention_q <= 1'b0;
    else     contention_q <= sel.clash;
  end
endmodule

// File: rtl/combo_bank_decoder_chk.sv
module combo_bank_decoder_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              flash_ce_n,
  input logic              ps_ce1_n,
  input logic              ps_ce2,
  input logic              oe_n,
  input logic              word_mode,
  input logic              flash_act,
  input logic              psram_act,
  input logic              standby,
  input logic              contention,
  input logic              contention_q,
  input logic              flash_wr,
  input logic              psram_wr,
  input logic [DATA_W-1:0] lane_oe,
  input logic [ADDR_W:0]   flash_addr
);
  localparam int LOW_LANES = DATA_W / 2;

  a_r3_one_bank: assert property (@(posedge clk) disable iff (rst)
    !(flash_act && psram_act));

  a_r3_clash_quiet: assert property (@(posedge clk) disable iff (rst)
    contention |-> (!flash_act && !psram_act && !flash_wr && !psram_wr && lane_oe == '0));

  a_r3_clash_pins: assert property (@(posedge clk) disable iff (rst)
    contention |-> (!flash_ce_n && !ps_ce1_n && ps_ce2));

  a_r4_standby_idle: assert property (@(posedge clk) disable iff (rst)
    standby |-> (!flash_act && !psram_act && !contention && lane_oe == '0));

  a_r5_no_oe_no_drive: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> lane_oe == '0);

  a_r6_byte_upper_off: assert property (@(posedge clk) disable iff (rst)
    (flash_act && !word_mode) |-> lane_oe[DATA_W-1:LOW_LANES] == '0);

  a_r7_word_addr_top: assert property (@(posedge clk) disable iff (rst)
    word_mode |-> !flash_addr[ADDR_W]);

  a_r8_psram_wr_qual: assert property (@(posedge clk) disable iff (rst)
    psram_wr |-> (psram_act && oe_n));

  a_r9_flash_wr_qual: assert property (@(posedge clk) disable iff (rst)
    flash_wr |-> (flash_act && oe_n));

  a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
    contention |=> contention_q);

  a_r10_flag_clear: assert property (@(posedge clk) disable iff (rst)
    !contention |=> !contention_q);
endmodule

bind combo_bank_decoder combo_bank_decoder_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .flash_ce_n   (flash_ce_n),
  .ps_ce1_n     (ps_ce1_n),
  .ps_ce2       (ps_ce2),
  .oe_n         (oe_n),
  .word_mode    (word_mode),
  .flash_act    (flash_act),
  .psram_act    (psram_act),
  .standby      (standby),
  .contention   (contention),
  .contention_q (contention_q),
  .flash_wr     (flash_wr),
  .psram_wr     (psram_wr),
  .lane_oe      (lane_oe),
  .flash_addr   (flash_addr)
);

// File: tb/combo_bank_decoder_tb.sv
module combo_bank_decoder_tb;
  localparam int DW = 16;
  localparam int AW = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flash_ce_n = 1'b1, ps_ce1_n = 1'b1, ps_ce2 = 1'b0;
  logic oe_n = 1'b1, we_n = 1'b1, word_mode = 1'b1, dq_msb = 1'b0;
  logic [AW-1:0] addr = '0;
  logic flash_act, psram_act, standby, contention, contention_q, flash_wr, psram_wr;
  logic [DW-1:0] lane_oe;
  logic [AW:0]   flash_addr;

  int n_cmp = 0;
  int n_bad = 0;
  logic exp_q = 1'b0;

  always #2 clk = ~clk;

  combo_bank_decoder #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .flash_ce_n(flash_ce_n), .ps_ce1_n(ps_ce1_n), .ps_ce2(ps_ce2),
    .oe_n(oe_n), .we_n(we_n), .word_mode(word_mode), .dq_msb(dq_msb), .addr(addr),
    .flash_act(flash_act), .psram_act(psram_act), .standby(standby), .contention(contention),
    .contention_q(contention_q), .flash_wr(flash_wr), .psram_wr(psram_wr),
    .lane_oe(lane_oe), .flash_addr(flash_addr)
  );

  // Reference for the registered flag: sampled at each rising edge.
  always @(posedge clk) begin
    if (rst) exp_q <= 1'b0;
    else     exp_q <= (flash_ce_n == 1'b0) && (ps_ce1_n == 1'b0) && (ps_ce2 == 1'b1);
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit f_on, p_on, clash, rd, exp_f, exp_p, exp_sb;
    longint exp_lanes, exp_addr;
    f_on  = (flash_ce_n == 1'b0);
    p_on  = (ps_ce1_n == 1'b0) && (ps_ce2 == 1'b1);
    clash = f_on && p_on;
    exp_f = clash ? 1'b0 : f_on;
    exp_p = clash ? 1'b0 : p_on;
    exp_sb = !f_on && !p_on;
    rd = (oe_n == 1'b0);
    if (exp_p && rd)                   exp_lanes = 'hFFFF;
    else if (exp_f && rd && word_mode) exp_lanes = 'hFFFF;
    else if (exp_f && rd)              exp_lanes = 'h00FF;
    else                               exp_lanes = 0;
    if (word_mode) exp_addr = longint'(addr);
    else           exp_addr = longint'(addr) * 2 + longint'(dq_msb);
    chk("R1", "flash_act", flash_act, exp_f);
    chk("R2", "psram_act", psram_act, exp_p);
    chk("R3", "contention", contention, clash);
    chk("R4", "standby", standby, exp_sb);
    if (word_mode || exp_p) chk("R5", "lane_oe", lane_oe, exp_lanes);
    else                    chk("R6", "lane_oe byte", lane_oe, exp_lanes);
    if (exp_p && rd && !word_mode) chk("R11", "psram lanes in byte mode", lane_oe, 'hFFFF);
    chk("R7", "flash_addr", flash_addr, exp_addr);
    chk("R8", "psram_wr", psram_wr, exp_p && !we_n && oe_n);
    chk("R9", "flash_wr", flash_wr, exp_f && !we_n && oe_n);
    chk("R10", "contention_q", contention_q, exp_q);
  endtask

  initial begin
    // Reset held while the contention code is applied.
    @(negedge clk);
    flash_ce_n = 1'b0; ps_ce1_n = 1'b0; ps_ce2 = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R10", "contention_q in reset", contention_q, 0);
    @(negedge clk);
    rst = 1'b0;
    flash_ce_n = 1'b1; ps_ce1_n = 1'b1; ps_ce2 = 1'b0;
    #1 check_all();
    for (int ap = 0; ap < 4; ap++) begin
      for (int v = 0; v < 128; v++) begin
        @(negedge clk);
        {flash_ce_n, ps_ce1_n, ps_ce2, oe_n, we_n, word_mode, dq_msb} = 7'(v);
        case (ap)
          0: addr = '0;
          1: addr = '1;
          2: addr = AW'(21'h155555);
          default: addr = AW'(21'h0AAAAA);
        endcase
        #1 check_all();
      end
    end
    // Back-to-back contention then release to watch the flag follow one edge late.
    @(negedge clk);
    flash_ce_n = 1'b0; ps_ce1_n = 1'b0; ps_ce2 = 1'b1;
    #1 check_all();
    @(negedge clk);
    #1 check_all();
    chk("R10", "flag after clash", contention_q, 1);
    @(negedge clk);
    flash_ce_n = 1'b1;
    #1 check_all();
    @(negedge clk);
    #1 check_all();
    chk("R10", "flag after release", contention_q, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule